// File: doc/BRIEF.md
# Windowed Readout Address Sequencer

This block produces the read addresses for one frame of a 320 x 256 pixel array. The array is read a row at a time, and two pixels leave on every clock. A rising edge on the frame sync input captures the window settings: the start column and row, the width and height, the two scan-direction flags and the output-channel count. It also resets the row count. Each later rising edge on the line sync input reads the next row of the window. During that row the block drives one row address and, per clock, two column addresses, each with its own valid strobe and output-channel number.

Pixel (0,0) is the lower-left corner of the array. Setting the column flip makes a row scan from the rightmost window column towards the left. Setting the row flip makes the frame start at the top window row and step downward. A pixel's output channel depends only on its physical column, taken modulo the channel count. The window position and the flip flags never change it, so the analog multiplexer that follows always sees a given pixel on the same output.

Top module: `rd_addr_seq`

## Requirements
- R1: Out of reset, `pixValid` is 0. Line sync pulses that come before the first frame sync rising edge produce no valid pixels.
- R2: A line sync rising edge sampled at clock edge k makes the row's first pixel pair visible after edge k. A new pair follows after each edge until the row is done. Lane 0 (`pixValid[0]`, `colAddr0`) carries the earlier pixel of each pair.
- R3: With both flip flags clear, rows run upward from the window start row. Within a row, columns run upward from the window start column.
- R4: With `flipCols` = 1, each row starts at the last window column (start + width - 1) and the column decreases by one per pixel.
- R5: With `flipRows` = 1, the first row read is the top window row (start + height - 1), and each following row is one lower.
- R6: The channel code is 0 for A, 1 for B, 2 for C and 3 for D. With `outMode` = 0 every pixel is on channel 0. With `outMode` = 1 the channel is column mod 2, and with `outMode` = 2 or 3 it is column mod 4. The flip flags and the window have no effect on it.
- R7: The window start column and the width are each rounded down to a multiple of the channel count before use.
- R8: The window is clipped at the right and top edges of the array. If the width is odd, `pixValid[1]` is 0 on the last pair of the row.
- R9: Line sync pulses are ignored once all window rows have been read, until the next frame sync edge. Line sync pulses that arrive while a row is still being read are also ignored.
- R10: A frame sync rising edge ends any row in progress. The valid strobes drop after that edge, and the next line sync reads the first window row again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame start; the rising edge captures the settings |
| lineSync | input | 1 | Row start; the rising edge reads the next window row |
| winColStart | input | 9 | Window start column |
| winRowStart | input | 8 | Window start row |
| winWidth | input | 9 | Window width in columns |
| winHeight | input | 9 | Window height in rows |
| flipRows | input | 1 | Scan rows from the top of the window downward |
| flipCols | input | 1 | Scan columns from right to left |
| outMode | input | 2 | Channel count: 0 gives one, 1 gives two, 2 or 3 gives four |
| rowAddr | output | 8 | Row address of the current pair |
| pixValid | output | 2 | Valid strobe per lane; bit 0 is the earlier pixel |
| colAddr0 | output | 9 | Column address of lane 0 |
| colAddr1 | output | 9 | Column address of lane 1 |
| chan0 | output | 2 | Output channel of lane 0 |
| chan1 | output | 2 | Output channel of lane 1 |

## Verification
There is one register stage between a sync input and the outputs. A line sync sampled at one edge shows pair 0 right after that edge. Pair p shows after the p-th following edge, and the strobes fall on the edge after the last pair. A frame sync edge clears the strobes on that same edge. The bench drives every input on the falling clock edge and then checks the outputs on each following falling edge. This way each expected pair is compared in the exact cycle it is due, and the idle cycle after a row is checked too. Expected columns and channels come from the window arithmetic written out in each scenario task.

// File: rtl/rd_seq_pkg.sv
package rd_seq_pkg;

  // Strobes from the control into the datapath; at most one of the first four per cycle.
  typedef struct packed {
    logic frameLoad;   // capture settings, clear row count
    logic lineStart;   // begin a row at pair 0
    logic pairStep;    // move to the next pair of the row
    logic lineEnd;     // last pair shown, advance the row count
    logic scanOn;      // a row is being emitted this cycle
  } seqStrobe_t;

  // Status the datapath reports back to the control.
  typedef struct packed {
    logic lastPair;
    logic lastRow;
    logic winEmpty;
  } seqStatus_t;

endpackage

// File: rtl/rd_seq_ctrl.sv
module rd_seq_ctrl
  import rd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       lineSync,
  input  seqStatus_t stat,
  output seqStrobe_t stb
);

  logic fsPrev, lsPrev, scanning, frameDone;
  logic fsRise, lsRise;

  assign fsRise = frameSync & ~fsPrev;
  assign lsRise = lineSync & ~lsPrev;

  always_comb begin
    stb           = '0;
    stb.frameLoad = fsRise;
    stb.scanOn    = scanning;
    if (!fsRise) begin
      if (scanning) begin
        if (stat.lastPair) stb.lineEnd  = 1'b1;
        else               stb.pairStep = 1'b1;
      end else if (lsRise && !frameDone && !stat.winEmpty) begin
        stb.lineStart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev    <= 1'b0;
      lsPrev    <= 1'b0;
      scanning  <= 1'b0;
      frameDone <= 1'b1;
    end else begin
      fsPrev <= frameSync;
      lsPrev <= lineSync;
      if (fsRise) begin
        scanning  <= 1'b0;
        frameDone <= 1'b0;
      end else if (stb.lineStart) begin
        scanning <= 1'b1;
      end else if (stb.lineEnd) begin
        scanning <= 1'b0;
        if (stat.lastRow) frameDone <= 1'b1;
      end
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.frameLoad, stb.lineStart, stb.pairStep, stb.lineEnd}));

  // R2
  line_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lineStart |=> stb.scanOn);

  // R10
  frame_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !fsPrev) |=> !stb.scanOn);

endmodule

// File: rtl/rd_seq_datapath.sv
module rd_seq_datapath
  import rd_seq_pkg::*;
#(
  parameter int COLS     = 320,
  parameter int ROWS     = 256,
  parameter int MAX_OUTS = 4,
  parameter int CW       = $clog2(COLS),
  parameter int RW       = $clog2(ROWS),
  parameter int CSZ      = $clog2(COLS + 1),
  parameter int RSZ      = $clog2(ROWS + 1),
  parameter int CHW      = $clog2(MAX_OUTS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               stb,
  input  logic [CW-1:0]            colStart,
  input  logic [RW-1:0]            rowStart,
  input  logic [CSZ-1:0]           width,
  input  logic [RSZ-1:0]           height,
  input  logic                     flipRows,
  input  logic                     flipCols,
  input  logic [1:0]               outMode,
  output seqStatus_t               stat,
  output logic [RW-1:0]            rowAddr,
  output logic [1:0]               pixValid,
  output logic [1:0][CW-1:0]       laneCol,
  output logic [1:0][CHW-1:0]      laneChan
);

  localparam int PW = $clog2(COLS / 2);

  // ---- settings captured on frame start, after rounding and clipping ----
  logic [CW-1:0]  newMask, csRound;
  logic [CSZ-1:0] colsAvail, wClip, wEff;
  logic [RSZ-1:0] rowsAvail, hEff;

  always_comb begin
    unique case (outMode)
      2'd0:    newMask = '0;
      2'd1:    newMask = CW'(1);
      default: newMask = CW'(MAX_OUTS - 1);
    endcase
    csRound   = colStart & ~newMask;
    colsAvail = (CSZ'(csRound) < CSZ'(COLS)) ? CSZ'(COLS) - CSZ'(csRound) : '0;
    wClip     = (width < colsAvail) ? width : colsAvail;
    wEff      = wClip & ~CSZ'(newMask);
    rowsAvail = (RSZ'(rowStart) < RSZ'(ROWS)) ? RSZ'(ROWS) - RSZ'(rowStart) : '0;
    hEff      = (height < rowsAvail) ? height : rowsAvail;
  end

  logic [CW-1:0]  cfgColStart;
  logic [RW-1:0]  cfgRowStart;
  logic [CSZ-1:0] cfgWidth;
  logic [RSZ-1:0] cfgHeight;
  logic           cfgFlipR, cfgFlipC;
  logic [CHW-1:0] cfgMask;
  logic [RSZ-1:0] rowOff;
  logic [PW-1:0]  pairIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgColStart <= '0;
      cfgRowStart <= '0;
      cfgWidth    <= '0;
      cfgHeight   <= '0;
      cfgFlipR    <= 1'b0;
      cfgFlipC    <= 1'b0;
      cfgMask     <= '0;
      rowOff      <= '0;
      pairIdx     <= '0;
    end else if (stb.frameLoad) begin
      cfgColStart <= csRound;
      cfgRowStart <= rowStart;
      cfgWidth    <= wEff;
      cfgHeight   <= hEff;
      cfgFlipR    <= flipRows;
      cfgFlipC    <= flipCols;
      cfgMask     <= newMask[CHW-1:0];
      rowOff      <= '0;
      pairIdx     <= '0;
    end else if (stb.lineStart) begin
      pairIdx <= '0;
    end else if (stb.pairStep) begin
      pairIdx <= pairIdx + PW'(1);
    end else if (stb.lineEnd) begin
      pairIdx <= '0;
      rowOff  <= rowOff + RSZ'(1);
    end
  end

  // ---- status back to control ----
  logic [CSZ-1:0] off0;
  assign off0          = CSZ'({pairIdx, 1'b0});
  assign stat.lastPair = (off0 + CSZ'(2)) >= cfgWidth;
  assign stat.lastRow  = (rowOff + RSZ'(1)) == cfgHeight;
  assign stat.winEmpty = (cfgWidth == '0) || (cfgHeight == '0);

  // ---- row address ----
  logic [RW-1:0] rowPhys;
  assign rowPhys = cfgFlipR
                 ? RW'(cfgRowStart) + RW'(cfgHeight) - RW'(1) - RW'(rowOff)
                 : RW'(cfgRowStart) + RW'(rowOff);
  assign rowAddr = stb.scanOn ? rowPhys : '0;

  // ---- two column lanes ----
  for (genvar g = 0; g < 2; g++) begin : gLane
    logic [CSZ-1:0] laneOff;
    logic [CW-1:0]  colPhys;
    logic           laneOn;
    assign laneOff = off0 + CSZ'(g);
    assign colPhys = cfgFlipC
                   ? CW'(cfgColStart) + CW'(cfgWidth) - CW'(1) - CW'(laneOff)
                   : CW'(cfgColStart) + CW'(laneOff);
    assign laneOn      = stb.scanOn && (laneOff < cfgWidth);
    assign pixValid[g] = laneOn;
    assign laneCol[g]  = laneOn ? colPhys : '0;
    assign laneChan[g] = laneOn ? (colPhys[CHW-1:0] & cfgMask) : '0;
  end

  // R8
  lane_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid[1] |-> pixValid[0]);

  // R8
  in_array_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid[0] |-> (32'(laneCol[0]) < COLS && 32'(rowAddr) < ROWS));

  // R3
  col_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pairStep && !cfgFlipC) |=> laneCol[0] == $past(laneCol[0]) + CW'(2));

  // R4
  col_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pairStep && cfgFlipC) |=> laneCol[0] == $past(laneCol[0]) - CW'(2));

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pairStep |=> $stable(rowAddr));

endmodule

// File: rtl/rd_addr_seq.sv
module rd_addr_seq
  import rd_seq_pkg::*;
#(
  parameter int COLS     = 320,
  parameter int ROWS     = 256,
  parameter int MAX_OUTS = 4,
  parameter int CW       = $clog2(COLS),
  parameter int RW       = $clog2(ROWS),
  parameter int CSZ      = $clog2(COLS + 1),
  parameter int RSZ      = $clog2(ROWS + 1),
  parameter int CHW      = $clog2(MAX_OUTS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           frameSync,
  input  logic           lineSync,
  input  logic [CW-1:0]  winColStart,
  input  logic [RW-1:0]  winRowStart,
  input  logic [CSZ-1:0] winWidth,
  input  logic [RSZ-1:0] winHeight,
  input  logic           flipRows,
  input  logic           flipCols,
  input  logic [1:0]     outMode,
  output logic [RW-1:0]  rowAddr,
  output logic [1:0]     pixValid,
  output logic [CW-1:0]  colAddr0,
  output logic [CW-1:0]  colAddr1,
  output logic [CHW-1:0] chan0,
  output logic [CHW-1:0] chan1
);

  seqStrobe_t          stb;
  seqStatus_t          stat;
  logic [1:0][CW-1:0]  laneCol;
  logic [1:0][CHW-1:0] laneChan;

  rd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .lineSync  (lineSync),
    .stat      (stat),
    .stb       (stb)
  );

  rd_seq_datapath #(
    .COLS     (COLS),
    .ROWS     (ROWS),
    .MAX_OUTS (MAX_OUTS),
    .CW       (CW),
    .RW       (RW),
    .CSZ      (CSZ),
    .RSZ      (RSZ),
    .CHW      (CHW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .colStart (winColStart),
    .rowStart (winRowStart),
    .width    (winWidth),
    .height   (winHeight),
    .flipRows (flipRows),
    .flipCols (flipCols),
    .outMode  (outMode),
    .stat     (stat),
    .rowAddr  (rowAddr),
    .pixValid (pixValid),
    .laneCol  (laneCol),
    .laneChan (laneChan)
  );

  assign colAddr0 = laneCol[0];
  assign colAddr1 = laneCol[1];
  assign chan0    = laneChan[0];
  assign chan1    = laneChan[1];

endmodule

// File: tb/rd_addr_seq_tb.sv
`timescale 1ns/1ps
module rd_addr_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0, lineSync = 1'b0;
  logic [8:0] winColStart = '0;
  logic [7:0] winRowStart = '0;
  logic [8:0] winWidth = '0;
  logic [8:0] winHeight = '0;
  logic       flipRows = 1'b0, flipCols = 1'b0;
  logic [1:0] outMode = '0;
  logic [7:0] rowAddr;
  logic [1:0] pixValid;
  logic [8:0] colAddr0, colAddr1;
  logic [1:0] chan0, chan1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rd_addr_seq u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .lineSync(lineSync),
    .winColStart(winColStart), .winRowStart(winRowStart),
    .winWidth(winWidth), .winHeight(winHeight),
    .flipRows(flipRows), .flipCols(flipCols), .outMode(outMode),
    .rowAddr(rowAddr), .pixValid(pixValid),
    .colAddr0(colAddr0), .colAddr1(colAddr1), .chan0(chan0), .chan1(chan1)
  );

  // Compare one cycle of output against expected values.
  task automatic chk(input string req, input logic [1:0] ev, input int er,
                     input int ec0, input int ech0, input int ec1, input int ech1);
    bit bad;
    checks++;
    bad = (pixValid !== ev);
    if (ev[0] && (rowAddr !== 8'(er) || colAddr0 !== 9'(ec0) || chan0 !== 2'(ech0))) bad = 1;
    if (ev[1] && (colAddr1 !== 9'(ec1) || chan1 !== 2'(ech1))) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%b row=%0d c0=%0d ch0=%0d c1=%0d ch1=%0d exp v=%b row=%0d c0=%0d ch0=%0d c1=%0d ch1=%0d",
               req, pixValid, rowAddr, colAddr0, chan0, colAddr1, chan1,
               ev, er, ec0, ech0, ec1, ech1);
    end
  endtask

  task automatic setWin(input int cs, input int rs, input int w, input int h,
                        input bit fr, input bit fc, input int mode);
    @(negedge clk);
    winColStart = 9'(cs); winRowStart = 8'(rs);
    winWidth = 9'(w); winHeight = 9'(h);
    flipRows = fr; flipCols = fc; outMode = 2'(mode);
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
  endtask

  // Pulse line sync and check every pair of the row, then the idle cycle.
  // cs, w are the effective (rounded, clipped) window values; n is the channel count.
  task automatic runLine(input string req, input int row, input int cs, input int w,
                         input bit fc, input int n, input bit midPulse);
    int pairs = (w + 1) / 2;
    @(negedge clk); lineSync = 1'b1;
    @(negedge clk); lineSync = 1'b0;
    for (int p = 0; p < pairs; p++) begin
      int o0 = 2 * p;
      int o1 = 2 * p + 1;
      int c0 = fc ? cs + w - 1 - o0 : cs + o0;
      int c1 = fc ? cs + w - 1 - o1 : cs + o1;
      logic [1:0] ev = {(o1 < w), 1'b1};
      if (p > 0) @(negedge clk);
      chk(req, ev, row, c0, c0 & (n - 1), c1, c1 & (n - 1));
      if (midPulse && p == 0) lineSync = 1'b1;
      if (midPulse && p == 1) lineSync = 1'b0;
    end
    @(negedge clk);
    chk({req, " idle after row"}, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic ignoredLine(input string req);
    @(negedge clk); lineSync = 1'b1;
    @(negedge clk); lineSync = 1'b0;
    chk(req, 2'b00, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(req, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 reset", 2'b00, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    ignoredLine("R1 line before frame");
  endtask

  task automatic tNormal();
    setWin(8, 10, 8, 2, 0, 0, 2);
    runLine("R3 R6 normal row0", 10, 8, 8, 0, 4, 0);
    runLine("R2 R3 normal row1", 11, 8, 8, 0, 4, 0);
  endtask

  task automatic tRevert();
    setWin(16, 0, 8, 1, 0, 1, 1);
    runLine("R4 R6 revert two-out", 0, 16, 8, 1, 2, 0);
    ignoredLine("R9 past last row");
  endtask

  task automatic tInvert();
    setWin(0, 20, 4, 3, 1, 0, 0);
    runLine("R5 invert top", 22, 0, 4, 0, 1, 0);
    runLine("R5 invert mid", 21, 0, 4, 0, 1, 0);
    runLine("R5 invert bottom", 20, 0, 4, 0, 1, 0);
    ignoredLine("R9 after invert frame");
  endtask

  task automatic tRound();
    setWin(6, 3, 10, 1, 0, 0, 2);   // start 6 -> 4, width 10 -> 8
    runLine("R7 rounding", 3, 4, 8, 0, 4, 0);
  endtask

  task automatic tClip();
    setWin(316, 254, 20, 5, 0, 0, 0);   // width -> 4, height -> 2
    runLine("R8 clip row254", 254, 316, 4, 0, 1, 0);
    runLine("R8 clip row255", 255, 316, 4, 0, 1, 0);
    ignoredLine("R8 R9 clipped rows");
    setWin(0, 0, 5, 1, 0, 0, 0);
    runLine("R8 odd width", 0, 0, 5, 0, 1, 0);
  endtask

  task automatic tBoth();
    setWin(0, 0, 8, 2, 1, 1, 3);
    runLine("R4 R5 R6 both flips", 1, 0, 8, 1, 4, 0);
    runLine("R4 R5 R6 both flips", 0, 0, 8, 1, 4, 0);
  endtask

  task automatic tAbort();
    setWin(0, 5, 16, 3, 0, 0, 0);
    @(negedge clk); lineSync = 1'b1;
    @(negedge clk); lineSync = 1'b0;
    chk("R10 first pair", 2'b11, 5, 0, 0, 1, 0);
    frameSync = 1'b1;
    @(negedge clk); frameSync = 1'b0;
    chk("R10 aborted", 2'b00, 0, 0, 0, 0, 0);
    runLine("R10 restart row", 5, 0, 16, 0, 1, 0);
    runLine("R10 next row", 6, 0, 16, 0, 1, 0);
  endtask

  task automatic tMidPulse();
    setWin(40, 100, 8, 2, 0, 0, 0);
    runLine("R9 pulse mid row", 100, 40, 8, 0, 1, 1);
    runLine("R9 row after mid pulse", 101, 40, 8, 0, 1, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tNormal();
    tRevert();
    tInvert();
    tRound();
    tClip();
    tBoth();
    tAbort();
    tMidPulse();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule